// File: doc/BRIEF.md
# Tick-Driven Timer/Counter with Compare Restart and Wide Mode

This block is a synchronous timer/counter that advances only on system clock cycles in which a one-cycle timer tick is high. It runs in one of three modes: an 8-bit free-running count, an 8-bit count that restarts from zero when it reaches a programmed top value, and a 16-bit free-running count. It raises a sticky match flag, a sticky wrap flag, and drives a compare pin whose reaction to a match is programmable.

Software-style writes reach the count, the top value, the run mode and the pin action through separate write strobes, each with its own data bus. Interrupt acknowledge is modelled by two clear inputs, one for each flag. Every tick is classified into one step kind: STEP_IDLE (no tick, no write), STEP_LOAD (count write), STEP_ADVANCE (plain increment), STEP_RESTART (top reached in restart mode, count goes to zero) or STEP_ROLL (count passes its maximum and goes to zero). The transitions are: any cycle with a count write goes to STEP_LOAD; otherwise a cycle without a tick is STEP_IDLE; a tick at the top value in restart mode is STEP_RESTART; a tick at the active maximum is STEP_ROLL; every other tick is STEP_ADVANCE.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0x0000, both flags and the compare pin are 0, the run mode is 8-bit free-running, the top value is 0x0000 and the pin action is "keep".
- R2: On a cycle with the tick low and no count write, the count does not change.
- R3: In 8-bit free-running mode (mode code 0) each tick adds one to the low byte, the upper byte reads zero, and the tick that takes the low byte from 0xFF to 0x00 sets the wrap flag on that same clock edge.
- R4: In restart mode (mode code 1) a tick on which the low byte equals the low byte of the top value makes the count 0x0000 and sets the match flag on that same edge.
- R5: In restart mode, when the count is already above the top value, no match occurs; the count runs to 0xFF, wraps to 0x00 setting the wrap flag, and only then can reach the top value.
- R6: In 16-bit mode (mode code 2) each tick adds one to the full count; the tick from 0xFFFF to 0x0000 sets the wrap flag on that edge, and reaching the top value does not restart the count.
- R7: In every mode, a tick on which the count equals the top value (low bytes only in the 8-bit modes, all 16 bits in 16-bit mode) sets the match flag.
- R8: Flags are only set by the hardware and only cleared by their clear input; a set and a clear on the same cycle leave the flag set.
- R9: A count write overrides the tick on the same cycle and raises no flag or pin event; in the 8-bit modes it loads the low byte and zeroes the upper byte.
- R10: On a match the compare pin reacts according to the pin action code: 0 keeps it, 1 toggles it, 2 drives it low, 3 drives it high; without a match it holds.
- R11: Mode code 3 behaves exactly like mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable, one cycle wide |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Value to load into the count |
| top_wr | input | 1 | Top value write strobe |
| top_wdata | input | 16 | New top value |
| mode_wr | input | 1 | Run mode write strobe |
| mode_wdata | input | 2 | Run mode code (0 narrow, 1 restart, 2 wide, 3 as 0) |
| pin_wr | input | 1 | Pin action write strobe |
| pin_wdata | input | 2 | Pin action code (0 keep, 1 toggle, 2 low, 3 high) |
| match_clr | input | 1 | Match flag acknowledge |
| wrap_clr | input | 1 | Wrap flag acknowledge |
| count | output | 16 | Current count |
| match_flag | output | 1 | Sticky match flag |
| wrap_flag | output | 1 | Sticky wrap flag |
| cmp_pin | output | 1 | Compare output pin |

## Verification
The assertions take for granted that every input is a known level on each rising edge after reset, and that the run mode and top value seen on a tick are the registered ones, so a configuration write lands one cycle before it governs a tick. The stimulus drives every input only at the falling edge, never changes configuration on a tick cycle, and returns every strobe to zero after one cycle, so each cycle is one well-defined step kind.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_NARROW  = 2'd0,
        MODE_RESTART = 2'd1,
        MODE_WIDE    = 2'd2,
        MODE_SPARE   = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        PIN_KEEP = 2'd0,
        PIN_FLIP = 2'd1,
        PIN_LOW  = 2'd2,
        PIN_HIGH = 2'd3
    } pin_act_e;

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_LOAD,
        STEP_ADVANCE,
        STEP_RESTART,
        STEP_ROLL
    } step_e;

endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  run_mode_e     mode,
    input  logic [CW-1:0] top,
    output logic [CW-1:0] count,
    output logic          hit,
    output logic          wrap
);

    localparam int UW = CW - NW;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [NW-1:0] low;
    logic [NW-1:0] low_inc;
    logic          narrow;
    logic          at_top;
    logic          at_max;
    step_e         step;

    assign low     = cnt_q[NW-1:0];
    assign low_inc = low + NW'(1);
    assign narrow  = (mode != MODE_WIDE);
    assign at_top  = narrow ? (low == top[NW-1:0]) : (cnt_q == top);
    assign at_max  = narrow ? (&low) : (&cnt_q);

    // step classification
    always_comb begin
        if (load) begin
            step = STEP_LOAD;
        end else if (!tick) begin
            step = STEP_IDLE;
        end else begin
            unique case (mode)
                MODE_RESTART: step = at_top ? STEP_RESTART :
                                     (at_max ? STEP_ROLL : STEP_ADVANCE);
                MODE_NARROW,
                MODE_SPARE,
                MODE_WIDE:    step = at_max ? STEP_ROLL : STEP_ADVANCE;
            endcase
        end
    end

    // next count and events
    always_comb begin
        cnt_d = cnt_q;
        hit   = 1'b0;
        wrap  = 1'b0;
        unique case (step)
            STEP_IDLE: cnt_d = cnt_q;
            STEP_LOAD: cnt_d = narrow ? {{UW{1'b0}}, load_val[NW-1:0]} : load_val;
            STEP_ADVANCE: begin
                cnt_d = narrow ? {{UW{1'b0}}, low_inc} : cnt_q + CW'(1);
                hit   = at_top;
            end
            STEP_RESTART: begin
                cnt_d = '0;
                hit   = 1'b1;
                wrap  = at_max;
            end
            STEP_ROLL: begin
                cnt_d = '0;
                hit   = at_top;
                wrap  = 1'b1;
            end
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count)); // R2
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && mode != MODE_WIDE) |=> (count[CW-1:NW] == '0)); // R3
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && mode == MODE_RESTART && count[NW-1:0] == top[NW-1:0])
        |=> (count == '0)); // R4
    AST_WIDE_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && mode == MODE_WIDE && (&count)) |=> (count == '0)); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode == MODE_WIDE) |=> (count == $past(load_val))); // R9

endmodule

// File: rtl/tmr_sticky_flag.sv
module tmr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(q)); // R8

endmodule

// File: rtl/tmr_wave_out.sv
module tmr_wave_out
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit,
    input  pin_act_e act,
    output logic     pin
);

    logic pin_d;

    always_comb begin
        pin_d = pin;
        if (hit) begin
            unique case (act)
                PIN_KEEP: pin_d = pin;
                PIN_FLIP: pin_d = ~pin;
                PIN_LOW:  pin_d = 1'b0;
                PIN_HIGH: pin_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_d;
    end

    AST_PIN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == PIN_FLIP) |=> (pin != $past(pin))); // R10
    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(pin)); // R10

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          top_wr,
    input  logic [CW-1:0] top_wdata,
    input  logic          mode_wr,
    input  logic [1:0]    mode_wdata,
    input  logic          pin_wr,
    input  logic [1:0]    pin_wdata,
    input  logic          match_clr,
    input  logic          wrap_clr,
    output logic [CW-1:0] count,
    output logic          match_flag,
    output logic          wrap_flag,
    output logic          cmp_pin
);

    run_mode_e     mode_q;
    pin_act_e      act_q;
    logic [CW-1:0] top_q;
    logic          hit;
    logic          wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_NARROW;
            act_q  <= PIN_KEEP;
            top_q  <= '0;
        end else begin
            if (mode_wr) mode_q <= run_mode_e'(mode_wdata);
            if (pin_wr)  act_q  <= pin_act_e'(pin_wdata);
            if (top_wr)  top_q  <= top_wdata;
        end
    end

    tmr_count_core #(.CW(CW), .NW(NW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .mode     (mode_q),
        .top      (top_q),
        .count    (count),
        .hit      (hit),
        .wrap     (wrap)
    );

    tmr_sticky_flag u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit),
        .clr   (match_clr),
        .q     (match_flag)
    );

    tmr_sticky_flag u_wrap (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wrap),
        .clr   (wrap_clr),
        .q     (wrap_flag)
    );

    tmr_wave_out u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .act   (act_q),
        .pin   (cmp_pin)
    );

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !match_flag && !match_clr) |=> !match_flag); // R9

endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick, cnt_wr, top_wr, mode_wr, pin_wr, match_clr, wrap_clr;
    logic [15:0] cnt_wdata, top_wdata;
    logic [1:0]  mode_wdata, pin_wdata;
    logic [15:0] count;
    logic        match_flag, wrap_flag, cmp_pin;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tick_timer u_tick_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .top_wr(top_wr), .top_wdata(top_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .pin_wr(pin_wr), .pin_wdata(pin_wdata),
        .match_clr(match_clr), .wrap_clr(wrap_clr),
        .count(count), .match_flag(match_flag),
        .wrap_flag(wrap_flag), .cmp_pin(cmp_pin)
    );

    typedef struct packed {
        logic        tk;
        logic        wr;
        logic [15:0] wd;
        logic [15:0] ec;
        logic        ew;
        logic        em;
    } vec_t;

    // restart mode, top = 3, starting from count 0 with flags clear
    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 16'h0000, 16'h0001, 1'b0, 1'b0},
        '{1'b0, 1'b0, 16'h0000, 16'h0001, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'h0000, 16'h0002, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'h0000, 16'h0003, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1},
        '{1'b1, 1'b1, 16'h0002, 16'h0002, 1'b0, 1'b1},
        '{1'b1, 1'b0, 16'h0000, 16'h0003, 1'b0, 1'b1},
        '{1'b1, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        tick = 0; cnt_wr = 0; top_wr = 0; mode_wr = 0; pin_wr = 0;
        match_clr = 0; wrap_clr = 0;
    endtask

    task automatic cfg(input logic [1:0] m, input logic [15:0] t, input logic [1:0] p);
        mode_wr = 1; mode_wdata = m; top_wr = 1; top_wdata = t; pin_wr = 1; pin_wdata = p;
        cyc();
    endtask

    task automatic load(input logic [15:0] v);
        cnt_wr = 1; cnt_wdata = v;
        cyc();
    endtask

    task automatic clrf();
        match_clr = 1; wrap_clr = 1;
        cyc();
    endtask

    task automatic tk();
        tick = 1;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; tick = 0; cnt_wr = 0; top_wr = 0; mode_wr = 0; pin_wr = 0;
        match_clr = 0; wrap_clr = 0; cnt_wdata = 0; top_wdata = 0;
        mode_wdata = 0; pin_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 flags", {match_flag, wrap_flag, cmp_pin}, 0);
        tk(); // default mode 0 with top 0: count 0 matches, count goes to 1
        chk("R1 default mode narrow", count, 16'h0001);
        chk("R1 default top zero", match_flag, 1);
        chk("R1 default pin keep", cmp_pin, 0);

        // R4 table walk
        cfg(2'd1, 16'h0003, 2'd0);
        load(16'h0000);
        clrf();
        for (int i = 0; i < 8; i++) begin
            tick = VECS[i].tk; cnt_wr = VECS[i].wr; cnt_wdata = VECS[i].wd;
            cyc();
            chk("R4 count", count, VECS[i].ec);         // vector 5 also covers R9
            chk("R4 flags", {wrap_flag, match_flag}, {VECS[i].ew, VECS[i].em});
        end

        // R5 top below count
        cfg(2'd1, 16'h0010, 2'd0);
        load(16'h0020);
        clrf();
        tk();
        chk("R5 no match above top", {count, match_flag}, {16'h0021, 1'b0});
        load(16'h00FE);
        tk();
        tk();
        chk("R5 wrap count", count, 16'h0000);
        chk("R5 wrap flag", {wrap_flag, match_flag}, 2'b10);
        load(16'h000F);
        tk();
        chk("R5 approach top", {count, match_flag}, {16'h0010, 1'b0});
        tk();
        chk("R5 match after wrap", {count, match_flag}, {16'h0000, 1'b1});

        // R8 sticky flags, set wins
        tk(); tk();
        chk("R8 flags persist", {wrap_flag, match_flag}, 2'b11);
        wrap_clr = 1;
        cyc();
        chk("R8 wrap cleared alone", {wrap_flag, match_flag}, 2'b01);
        load(16'h00FF);
        tick = 1; wrap_clr = 1;
        cyc();
        chk("R8 set beats clear", {count, wrap_flag}, {16'h0000, 1'b1});

        // R2 no tick
        cfg(2'd0, 16'h0099, 2'd0);
        load(16'h0040);
        cyc(); cyc(); cyc();
        chk("R2 idle hold", count, 16'h0040);

        // R3 narrow wrap
        load(16'h00FE);
        clrf();
        tk();
        chk("R3 step", {count, wrap_flag}, {16'h00FF, 1'b0});
        tk();
        chk("R3 wrap", {count, wrap_flag}, {16'h0000, 1'b1});

        // R9 write width and priority
        load(16'h12FE);
        chk("R9 narrow load", count, 16'h00FE);
        load(16'h00FF);
        clrf();
        tick = 1; cnt_wr = 1; cnt_wdata = 16'h0030;
        cyc();
        chk("R9 write over tick", {count, wrap_flag}, {16'h0030, 1'b0});

        // R7 narrow match without restart
        cfg(2'd0, 16'h0005, 2'd0);
        load(16'h0005);
        clrf();
        tk();
        chk("R7 narrow match", {count, match_flag}, {16'h0006, 1'b1});

        // R6 wide mode
        cfg(2'd2, 16'h0100, 2'd0);
        load(16'hFFFE);
        clrf();
        tk();
        chk("R6 to max", {count, wrap_flag}, {16'hFFFF, 1'b0});
        tk();
        chk("R6 wrap", {count, wrap_flag}, {16'h0000, 1'b1});
        load(16'h00FF);
        clrf();
        tk();
        chk("R7 wide no early match", {count, match_flag}, {16'h0100, 1'b0});
        tk();
        chk("R6 R7 wide match no restart", {count, match_flag}, {16'h0101, 1'b1});

        // R11 spare code
        cfg(2'd3, 16'h0099, 2'd0);
        load(16'h12FF);
        clrf();
        tk();
        chk("R11 spare acts narrow", {count, wrap_flag}, {16'h0000, 1'b1});

        // R10 pin actions, restart mode with top 0 matches every tick
        cfg(2'd1, 16'h0000, 2'd1);
        load(16'h0000);
        chk("R10 pin start", cmp_pin, 0);
        tk();
        chk("R10 toggle high", cmp_pin, 1);
        tk();
        chk("R10 toggle low", cmp_pin, 0);
        cfg(2'd1, 16'h0000, 2'd3);
        tk();
        chk("R10 set", cmp_pin, 1);
        cfg(2'd1, 16'h0000, 2'd0);
        tk();
        chk("R10 keep", cmp_pin, 1);
        cfg(2'd1, 16'h0000, 2'd2);
        tk();
        chk("R10 clear", cmp_pin, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule